// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Set

This block holds the control and status registers of a bus-master DMA channel that works next to a SCSI protocol core. Software programs a starting transfer count, a starting memory address and a starting descriptor address. It then writes a command word whose two low bits select one of four operations. The start operation copies the three starting values into their working counterparts, wipes the status flags and enables the channel. The abort operation sends a one-cycle cancel strobe to the core. The idle operation disables the channel.

While a transfer runs, the memory engine offers data in chunks through a small handshake that carries a length and a direction. If the direction disagrees with the command's direction bit, the block refuses the chunk. Otherwise it grants a length no greater than the remaining working count, lowers the count by the granted amount and advances the working address by the same amount. A command-complete strobe from the core zeroes the count and raises the done flag. The error, abort and done flags are sticky. They are cleared either by writing ones to them or by reading the status register; an input strap selects which of the two modes applies.

Top module: `dmach_regs`

## Requirements
- R1: After reset, the command (index 0), the three start registers (1, 2, 6), the working count (3) and the status (5) read 0. The working address (4) reads 0xFFFFFFFF, the working descriptor address (7) reads 0xFFFFFFFD, and `dma_en` is 0.
- R2: A write to index 0 stores the full 32-bit word. Bits [1:0] select the opcode: 0 clears `dma_en`, 1 leaves all state other than the command word unchanged, 2 pulses `core_cancel` high for exactly the cycle after the write, and 3 sets `dma_en`.
- R3: Opcode 3 loads index 3 from index 1, index 4 from index 2 and index 7 from index 6. The new values are visible on the cycle after the write.
- R4: Opcode 3 clears status bits [5:0].
- R5: With `rd_clears_status` = 0, a write to index 5 clears status bit 1 (error), bit 2 (abort) and bit 3 (done) at each position where the written data holds a 1. Written ones at any other position have no effect, and a read does not clear anything.
- R6: With `rd_clears_status` = 1, writes to index 5 are ignored. A read of index 5 returns the current bits, and bits 1 to 3 are cleared on the following cycle.
- R7: A read of index 5 returns bit 4 set whenever `core_irq` is high, in addition to the stored bits.
- R8: A chunk is accepted (`chunk_accept` = 1) only when `chunk_dir` equals command bit 7 (1 = device to memory). A refused chunk leaves the working count and address unchanged.
- R9: For an accepted chunk, `chunk_grant` equals the smaller of `chunk_len` and the working count. At the next clock edge, the working count drops by `chunk_grant` and the working address rises by it.
- R10: A `cmd_done` pulse sets the working count to 0 and status bit 3.
- R11: Writes to indices 3, 4 and 7 are ignored. A read of any index returns its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read-side clearing) |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| rd_clears_status | input | 1 | Selects the sticky-clear mode: 1 = clear on read, 0 = clear by writing ones |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| cmd_done | input | 1 | Command-complete strobe from the SCSI core |
| chunk_valid | input | 1 | A chunk transfer is offered |
| chunk_dir | input | 1 | Chunk direction, 1 = device to memory |
| chunk_len | input | LEN_W | Requested chunk length in bytes |
| chunk_accept | output | 1 | Chunk direction matches and the chunk is taken |
| chunk_grant | output | 32 | Granted length, clipped to the working count |
| dma_en | output | 1 | Channel enable to the SCSI core |
| core_cancel | output | 1 | One-cycle cancel strobe to the SCSI core |

## Verification
The chunk path is tested with a sequence of offers that mixes matching and opposing directions, a zero-length chunk, a length that exceeds the remaining count and an offer made after the count has reached zero. Together these separate refusal from clipping from plain decrement, and they show that a refused chunk leaves the address untouched. The path is tested again with the direction bit set, so that the comparison is proven in both polarities. The sticky flags are exercised in both clearing modes: write ones on non-sticky positions, write while in read-clear mode, and two back-to-back reads. These cases tell the two modes apart from each other, and the interrupt overlay is kept apart from the stored bits.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int REG_W = 32;
  localparam int NREG  = 8;
  localparam int IDX_W = $clog2(NREG);

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_BLAST = 2'd1, OP_ABORT = 2'd2, OP_START = 2'd3} op_e;

  localparam logic [IDX_W-1:0] IX_CMD   = 3'd0;
  localparam logic [IDX_W-1:0] IX_SCNT  = 3'd1;
  localparam logic [IDX_W-1:0] IX_SADR  = 3'd2;
  localparam logic [IDX_W-1:0] IX_WCNT  = 3'd3;
  localparam logic [IDX_W-1:0] IX_WADR  = 3'd4;
  localparam logic [IDX_W-1:0] IX_STAT  = 3'd5;
  localparam logic [IDX_W-1:0] IX_SDESC = 3'd6;
  localparam logic [IDX_W-1:0] IX_WDESC = 3'd7;

  localparam int CB_DIR  = 7;
  localparam int SB_DONE = 3;
  localparam int SB_IRQ  = 4;

  localparam logic [REG_W-1:0] STICKY_MASK = 32'h0000_000E;
  localparam logic [REG_W-1:0] START_CLR   = 32'h0000_003F;
  localparam logic [REG_W-1:0] RST_WADR    = 32'hFFFF_FFFF;
  localparam logic [REG_W-1:0] RST_WDESC   = 32'hFFFF_FFFD;

  function automatic logic [REG_W-1:0] clip_len(input logic [REG_W-1:0] want,
                                                input logic [REG_W-1:0] avail);
    return (want < avail) ? want : avail;
  endfunction

  function automatic logic [REG_W-1:0] sticky_clear(input logic [REG_W-1:0] stat,
                                                    input logic [REG_W-1:0] ones);
    return stat & ~(ones & STICKY_MASK);
  endfunction
endpackage

// File: rtl/dmach_cmd_dec.sv
module dmach_cmd_dec
  import dmach_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [REG_W-1:0] wdata,
  output logic             start_evt,
  output logic             dma_en,
  output logic             core_cancel
);
  op_e op;
  logic idle_evt, abort_evt;

  assign op        = op_e'(wdata[1:0]);
  assign start_evt = cmd_wr && (op == OP_START);
  assign idle_evt  = cmd_wr && (op == OP_IDLE);
  assign abort_evt = cmd_wr && (op == OP_ABORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_en      <= 1'b0;
      core_cancel <= 1'b0;
    end else begin
      core_cancel <= abort_evt;
      if (start_evt)     dma_en <= 1'b1;
      else if (idle_evt) dma_en <= 1'b0;
    end
  end
endmodule

// File: rtl/dmach_status.sv
module dmach_status
  import dmach_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             stat_wr,
  input  logic             stat_rd,
  input  logic             rd_mode,
  input  logic [REG_W-1:0] wdata,
  input  logic             cmd_done,
  output logic [REG_W-1:0] stat_q
);
  logic [REG_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (start_evt)           stat_d = stat_d & ~START_CLR;
    if (stat_wr && !rd_mode) stat_d = sticky_clear(stat_d, wdata);
    if (stat_rd && rd_mode)  stat_d = sticky_clear(stat_d, '1);
    if (cmd_done)            stat_d[SB_DONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/dmach_xfer.sv
module dmach_xfer
  import dmach_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             chunk_valid,
  input  logic             chunk_dir,
  input  logic [LEN_W-1:0] chunk_len,
  input  logic             cmd_dir,
  input  logic [REG_W-1:0] wcnt,
  output logic             accept,
  output logic [REG_W-1:0] grant
);
  logic [REG_W-1:0] want;

  assign want   = REG_W'(chunk_len);
  assign accept = chunk_valid && (chunk_dir == cmd_dir);
  assign grant  = accept ? clip_len(want, wcnt) : '0;
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             rd_clears_status,
  input  logic             core_irq,
  input  logic             cmd_done,
  input  logic             chunk_valid,
  input  logic             chunk_dir,
  input  logic [LEN_W-1:0] chunk_len,
  output logic             chunk_accept,
  output logic [31:0]      chunk_grant,
  output logic             dma_en,
  output logic             core_cancel
);
  logic [REG_W-1:0] cmd_q, scnt_q, sadr_q, sdesc_q;
  logic [REG_W-1:0] wcnt_q, wadr_q, wdesc_q, stat_q;
  logic             start_evt, cmd_dir;
  logic [NREG-1:0]  wr_sel;

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_sel
      assign wr_sel[gi] = reg_wr && (reg_idx == IDX_W'(gi));
    end
  endgenerate

  assign cmd_dir = cmd_q[CB_DIR];

  dmach_cmd_dec u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(wr_sel[IX_CMD]), .wdata(reg_wdata),
    .start_evt(start_evt), .dma_en(dma_en), .core_cancel(core_cancel)
  );

  dmach_status u_stat (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt),
    .stat_wr(wr_sel[IX_STAT]), .stat_rd(reg_rd && (reg_idx == IX_STAT)),
    .rd_mode(rd_clears_status), .wdata(reg_wdata), .cmd_done(cmd_done),
    .stat_q(stat_q)
  );

  dmach_xfer #(.LEN_W(LEN_W)) u_xfer (
    .chunk_valid(chunk_valid), .chunk_dir(chunk_dir), .chunk_len(chunk_len),
    .cmd_dir(cmd_dir), .wcnt(wcnt_q), .accept(chunk_accept), .grant(chunk_grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      scnt_q  <= '0;
      sadr_q  <= '0;
      sdesc_q <= '0;
    end else begin
      if (wr_sel[IX_CMD])   cmd_q   <= reg_wdata;
      if (wr_sel[IX_SCNT])  scnt_q  <= reg_wdata;
      if (wr_sel[IX_SADR])  sadr_q  <= reg_wdata;
      if (wr_sel[IX_SDESC]) sdesc_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      wadr_q  <= RST_WADR;
      wdesc_q <= RST_WDESC;
    end else if (start_evt) begin
      wcnt_q  <= scnt_q;
      wadr_q  <= sadr_q;
      wdesc_q <= sdesc_q;
    end else begin
      if (cmd_done)          wcnt_q <= '0;
      else if (chunk_accept) wcnt_q <= wcnt_q - chunk_grant;
      if (chunk_accept)      wadr_q <= wadr_q + chunk_grant;
    end
  end

  always_comb begin
    unique case (reg_idx)
      IX_CMD:   reg_rdata = cmd_q;
      IX_SCNT:  reg_rdata = scnt_q;
      IX_SADR:  reg_rdata = sadr_q;
      IX_WCNT:  reg_rdata = wcnt_q;
      IX_WADR:  reg_rdata = wadr_q;
      IX_STAT:  reg_rdata = stat_q | (REG_W'(core_irq) << SB_IRQ);
      IX_SDESC: reg_rdata = sdesc_q;
      default:  reg_rdata = wdesc_q;
    endcase
  end
endmodule

// File: rtl/dmach_regs_chk.sv
module dmach_regs_chk
  import dmach_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_idx,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             rd_clears_status,
  input logic             core_irq,
  input logic             cmd_done,
  input logic             chunk_valid,
  input logic             chunk_dir,
  input logic             chunk_accept,
  input logic [31:0]      chunk_grant,
  input logic             core_cancel,
  input logic             start_evt,
  input logic             cmd_dir,
  input logic [REG_W-1:0] wcnt_q,
  input logic [REG_W-1:0] scnt_q,
  input logic [REG_W-1:0] stat_q
);
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> wcnt_q == $past(scnt_q)); // R3

  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !cmd_done |=> stat_q[5:0] == 6'd0); // R4

  AST_CANCEL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    core_cancel |-> $past(reg_wr && reg_idx == IX_CMD && reg_wdata[1:0] == 2'd2)); // R2

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && !start_evt |=> wcnt_q == '0 && stat_q[SB_DONE]); // R10

  AST_DIR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && (chunk_dir != cmd_dir) |-> !chunk_accept); // R8

  AST_CHUNK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_accept && !start_evt && !cmd_done |=> wcnt_q == $past(wcnt_q) - $past(chunk_grant)); // R9

  AST_IRQ_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx == IX_STAT && core_irq |-> reg_rdata[SB_IRQ]); // R7

  AST_RDMODE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clears_status && reg_wr && reg_idx == IX_STAT && !reg_rd && !cmd_done
    |=> stat_q == $past(stat_q)); // R6
endmodule

bind dmach_regs dmach_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_clears_status(rd_clears_status),
  .core_irq(core_irq), .cmd_done(cmd_done), .chunk_valid(chunk_valid),
  .chunk_dir(chunk_dir), .chunk_accept(chunk_accept), .chunk_grant(chunk_grant),
  .core_cancel(core_cancel), .start_evt(start_evt), .cmd_dir(cmd_dir),
  .wcnt_q(wcnt_q), .scnt_q(scnt_q), .stat_q(stat_q)
);

// File: tb/dmach_regs_bench.sv
module dmach_regs_bench;
  localparam int LEN_W = 16;
  localparam int NVEC  = 6;
  // each entry: {direction, length}
  localparam logic [LEN_W:0] VEC [NVEC] = '{
    {1'b0, 16'd10}, {1'b1, 16'd5}, {1'b0, 16'd30},
    {1'b0, 16'd0},  {1'b0, 16'd70}, {1'b0, 16'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, rd_clears_status = 0, core_irq = 0, cmd_done = 0;
  logic chunk_valid = 0, chunk_dir = 0;
  logic [2:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, chunk_grant;
  logic [LEN_W-1:0] chunk_len = '0;
  logic chunk_accept, dma_en, core_cancel;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  dmach_regs #(.LEN_W(LEN_W)) u_dmach_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_clears_status(rd_clears_status),
    .core_irq(core_irq), .cmd_done(cmd_done), .chunk_valid(chunk_valid),
    .chunk_dir(chunk_dir), .chunk_len(chunk_len), .chunk_accept(chunk_accept),
    .chunk_grant(chunk_grant), .dma_en(dma_en), .core_cancel(core_cancel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_idx = idx; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_idx = idx; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); cmd_done = 1;
    @(negedge clk); cmd_done = 0;
  endtask

  task automatic chunk(input logic dir, input logic [LEN_W-1:0] len,
                       output logic acc, output logic [31:0] g);
    @(negedge clk); chunk_valid = 1; chunk_dir = dir; chunk_len = len;
    #1 acc = chunk_accept; g = chunk_grant;
    @(negedge clk); chunk_valid = 0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic acc;
    logic [31:0] g, rem, adr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(3'd0, v); check("R1 cmd", v, 0);
    rd(3'd1, v); check("R1 start count", v, 0);
    rd(3'd3, v); check("R1 working count", v, 0);
    rd(3'd4, v); check("R1 working address", v, 32'hFFFF_FFFF);
    rd(3'd5, v); check("R1 status", v, 0);
    rd(3'd7, v); check("R1 working descriptor", v, 32'hFFFF_FFFD);
    check("R1 dma_en", {31'd0, dma_en}, 0);

    // R3 start load, direction 0
    wr(3'd1, 32'd100); wr(3'd2, 32'h1000); wr(3'd6, 32'h2000);
    wr(3'd0, 32'h0000_0003);
    rd(3'd3, v); check("R3 count loaded", v, 100);
    rd(3'd4, v); check("R3 address loaded", v, 32'h1000);
    rd(3'd7, v); check("R3 descriptor loaded", v, 32'h2000);
    rd(3'd0, v); check("R2 command stored", v, 3);
    check("R2 start enables", {31'd0, dma_en}, 1);

    // R8 R9 chunk vectors
    rem = 100; adr = 32'h1000;
    for (int i = 0; i < NVEC; i++) begin
      logic ea;
      logic [31:0] eg;
      ea = (VEC[i][LEN_W] == 1'b0);
      eg = ea ? ((32'(VEC[i][LEN_W-1:0]) < rem) ? 32'(VEC[i][LEN_W-1:0]) : rem) : 0;
      chunk(VEC[i][LEN_W], VEC[i][LEN_W-1:0], acc, g);
      check("R8 accept", {31'd0, acc}, {31'd0, ea});
      if (ea) check("R9 grant", g, eg);
      rem = rem - eg; adr = adr + eg;
      rd(3'd3, v); check("R9 working count", v, rem);
      rd(3'd4, v); check("R9 working address", v, adr);
    end

    // R11 working registers ignore writes
    wr(3'd3, 32'h55); wr(3'd4, 32'h66); wr(3'd7, 32'h77);
    rd(3'd3, v); check("R11 count write ignored", v, rem);
    rd(3'd4, v); check("R11 address write ignored", v, adr);
    rd(3'd7, v); check("R11 descriptor write ignored", v, 32'h2000);

    // R10 command complete
    wr(3'd0, 32'h3);
    rd(3'd3, v); check("R3 reload", v, 100);
    done_pulse();
    rd(3'd3, v); check("R10 count zeroed", v, 0);
    rd(3'd5, v); check("R10 done set", v, 32'h08);

    // R7 interrupt overlay
    core_irq = 1;
    rd(3'd5, v); check("R7 irq visible", v, 32'h18);
    core_irq = 0;
    rd(3'd5, v); check("R7 irq gone, R5 read keeps done", v, 32'h08);

    // R5 write-one-to-clear
    wr(3'd5, 32'h30);
    rd(3'd5, v); check("R5 non-sticky ones ignored", v, 32'h08);
    wr(3'd5, 32'h08);
    rd(3'd5, v); check("R5 done cleared", v, 0);

    // R6 clear on read
    done_pulse();
    rd_clears_status = 1;
    wr(3'd5, 32'hFF);
    rd(3'd5, v); check("R6 write ignored, read returns done", v, 32'h08);
    rd(3'd5, v); check("R6 cleared by read", v, 0);
    rd_clears_status = 0;

    // R4 start clears status
    done_pulse();
    wr(3'd0, 32'h3);
    rd(3'd5, v); check("R4 start clears status", v, 0);

    // R2 abort, blast, idle
    @(negedge clk); reg_wr = 1; reg_idx = 3'd0; reg_wdata = 32'h2;
    @(posedge clk); #1 check("R2 cancel pulse", {31'd0, core_cancel}, 1);
    @(negedge clk); reg_wr = 0;
    @(posedge clk); #1 check("R2 cancel one cycle", {31'd0, core_cancel}, 0);
    check("R2 abort keeps enable", {31'd0, dma_en}, 1);
    wr(3'd0, 32'h1);
    check("R2 blast keeps enable", {31'd0, dma_en}, 1);
    rd(3'd3, v); check("R2 blast keeps count", v, 100);
    wr(3'd0, 32'h0);
    check("R2 idle disables", {31'd0, dma_en}, 0);

    // R8 direction 1
    wr(3'd1, 32'd20); wr(3'd0, 32'h83);
    chunk(1'b1, 16'd8, acc, g);
    check("R8 dir1 accept", {31'd0, acc}, 1);
    check("R9 dir1 grant", g, 8);
    chunk(1'b0, 16'd4, acc, g);
    check("R8 dir0 refused", {31'd0, acc}, 0);
    rd(3'd3, v); check("R8 refused leaves count", v, 12);

    finish_run();
  end
endmodule